// File: doc/BRIEF.md
# SPI Status and Mode-Fault Logic

This block is the data and status core of a byte-wide SPI peripheral. It can run as a bus master or as a bus slave. A host writes bytes into a transmit holding register and reads completed bytes from a receive holding register. An internal shift register moves each byte across the serial pins. The clock mode is fixed: SCK idles low, data is sampled on the rising edge and shifted on the falling edge, and the most significant bit goes first.

Three status flags record events. The transmit-empty flag sets when the holding register hands its byte to the shifter. The receive-full flag sets when the shifter hands a finished byte to the receive register. The mode-fault flag sets when the slave-select pin behaves in a way that conflicts with the current role. Each flag has its own enable, and the enabled flags are combined into a single interrupt request.

The slave-select pin, the slave SCK input and the slave MOSI input each pass through a two-flop synchronizer before they are used. A mode fault seen as master stops the transfer and demotes the block to slave.

Top module: `spi_status_core`

## Requirements
- R1: After reset, `tx_empty` is 1 and `rx_full`, `mode_fault`, `busy`, `is_master`, `irq` and `sck_out` are all 0.
- R2: As master, a transfer starts one cycle after a byte is pending in the transmit register. `sck_out` starts low, toggles every `HALF_DIV` clocks and gives 8 pulses. `mosi_out` presents bit 7 first and holds each bit through its high phase. `miso_in` is sampled on each rising SCK. `busy` drops after the 8th falling edge.
- R3: `tx_empty` goes to 1 in the cycle a byte moves from the transmit register into the shifter. A `wr_tx` pulse clears it. If a write and a handoff fall in the same cycle, the old byte is shifted out, the new byte is kept, and the flag reads 0.
- R4: When the 8th bit completes, `rx_data` takes the received byte (first bit received in bit 7) and `rx_full` goes to 1. An `rd_rx` pulse clears `rx_full`. If completion and `rd_rx` coincide, the flag stays set.
- R5: `irq` is 1 exactly when at least one of (`rx_full` and `rx_ie`), (`tx_empty` and `tx_ie`), (`mode_fault` and `err_ie`) holds. A flag whose enable is 0 has no effect on `irq`.
- R6: As slave, a transfer starts on a synchronized falling edge of `ss_n_in` and loads the transmit register, which sets `tx_empty`. `mosi_in` is sampled on synchronized SCK rising edges and shifted on falling edges. `miso_out` shows the current most significant bit. After 8 falling edges the byte is delivered as in R4.
- R7: As slave with `fault_det_en` = 1, `ss_n_in` returning high during a transfer sets `mode_fault` and abandons the partial byte, leaving `rx_full` unchanged. With `fault_det_en` = 0 the partial byte is dropped and `mode_fault` stays 0.
- R8: As master with `fault_det_en` = 1, a low level on the synchronized `ss_n_in` sets `mode_fault`, whether idle or busy. In the same cycle it aborts any transfer (`busy` and `sck_out` go to 0) and forces `is_master` to 0. With `fault_det_en` = 0 a low `ss_n_in` has no effect.
- R9: A `clr_fault` pulse clears `mode_fault`. A new fault in the same cycle wins and leaves the flag at 1.
- R10: `is_master` follows `master_en` only while `busy` is 0. After a master mode fault it stays 0 until `master_en` has been seen low.
- R11: A change on `ss_n_in` reaches the fault logic after two synchronizer flops. A master fault caused by `ss_n_in` falling is visible on `mode_fault` at the third rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_en | input | 1 | Requested role: 1 master, 0 slave |
| fault_det_en | input | 1 | Enables mode-fault detection |
| rx_ie | input | 1 | Receive-full interrupt enable |
| tx_ie | input | 1 | Transmit-empty interrupt enable |
| err_ie | input | 1 | Mode-fault interrupt enable |
| wr_tx | input | 1 | Write strobe for the transmit register |
| wr_data | input | DATA_W | Byte written to the transmit register |
| rd_rx | input | 1 | Read strobe for the receive register (clears rx_full) |
| clr_fault | input | 1 | Write-one-to-clear strobe for mode_fault |
| rx_data | output | DATA_W | Receive register contents |
| tx_empty | output | 1 | Transmit register free |
| rx_full | output | 1 | Receive register holds an unread byte |
| mode_fault | output | 1 | Mode-fault flag |
| is_master | output | 1 | Current role |
| busy | output | 1 | Shifter is moving a byte |
| irq | output | 1 | Combined interrupt request |
| ss_n_in | input | 1 | Slave-select pin, active low |
| sck_in | input | 1 | Serial clock when slave |
| mosi_in | input | 1 | Serial data in when slave |
| miso_in | input | 1 | Serial data in when master |
| sck_out | output | 1 | Serial clock when master |
| mosi_out | output | 1 | Serial data out when master (0 as slave) |
| miso_out | output | 1 | Serial data out when slave (0 as master) |

## Verification
A corrupted shifter or bit counter shows up at once as a wrong `sck_out` or `mosi_out` level inside the same half period. It also shows up one byte time later as a wrong `rx_data` or a `busy` that ends a cycle early or late. A wrong flag or role register shows on `tx_empty`, `rx_full`, `mode_fault`, `is_master` and `irq` in the cycle after the event that should have moved it. The bench catches both kinds by comparing every output on every clock against a behavioural model of the timing. A synchronizer with the wrong depth shifts the fault and slave-start timing by a cycle, which the per-cycle comparison detects as soon as `ss_n_in` moves.

// File: rtl/spi_stat_pkg.sv
// Package: shared constants for the SPI status core.
// Assumes: the synchronized pin vector is ordered {mosi, sck, ss_n}.
package spi_stat_pkg;
    localparam int SYNC_W   = 3;
    localparam int SS_BIT   = 0;
    localparam int SCK_BIT  = 1;
    localparam int MOSI_BIT = 2;
    // Idle levels: ss_n high, sck low, mosi low.
    localparam logic [SYNC_W-1:0] SYNC_IDLE = 3'b001;

    localparam int IRQ_SRCS = 3;
    localparam int SRC_RX   = 0;
    localparam int SRC_TX   = 1;
    localparam int SRC_ERR  = 2;
endpackage

// File: rtl/spi_stat_sync.sv
// Module: two-flop synchronizer, one independent chain per bit.
// Assumes: each input bit is asynchronous to clk; RST_VAL gives the idle level per bit.
module spi_stat_sync #(
    parameter int              W       = 3,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q;
        logic stab_q;
        // Purpose: move one pin bit into the clk domain through two flops.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[i];
                stab_q <= RST_VAL[i];
            end else begin
                meta_q <= d[i];
                stab_q <= meta_q;
            end
        end
        assign q[i] = stab_q;
    end
endmodule

// File: rtl/spi_stat_shifter.sv
// Module: shared serial shifter for master and slave roles, SCK mode 0, MSB first.
// Assumes: start and abort never coincide with a role change; slave sck/mosi are
// already synchronized; in master mode miso_in is stable around rising SCK.
module spi_stat_shifter #(
    parameter int DATA_W   = 8,
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_master,
    input  logic              start,
    input  logic              abort,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              sck_q,
    input  logic              mosi_q,
    input  logic              miso_in,
    output logic              active,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte,
    output logic              sck_o,
    output logic              ser_out
);
    localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam int DIV_W = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
    localparam logic [DIV_W-1:0] DIV_TOP  = DIV_W'(HALF_DIV - 1);

    logic [DATA_W-1:0] sreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DIV_W-1:0]  div_q;
    logic              samp_q;
    logic              sck_prev_q;
    logic              tick;
    logic              sample_now;
    logic              shift_now;
    logic              in_bit;

    // Purpose: find this cycle's sample and shift events for the current role.
    always_comb begin
        tick = (div_q == DIV_TOP);
        if (is_master) begin
            sample_now = tick && !sck_o;
            shift_now  = tick && sck_o;
            in_bit     = miso_in;
        end else begin
            sample_now = sck_q && !sck_prev_q;
            shift_now  = !sck_q && sck_prev_q;
            in_bit     = mosi_q;
        end
    end

    assign done    = active && !abort && !start && shift_now && (cnt_q == LAST_BIT);
    assign rx_byte = {sreg_q[DATA_W-2:0], samp_q};
    assign ser_out = sreg_q[DATA_W-1];

    // Purpose: remember the last synchronized slave SCK level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev_q <= 1'b0;
        else        sck_prev_q <= sck_q;
    end

    // Purpose: load, clock, shift and end one byte transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            sreg_q <= '0;
            cnt_q  <= '0;
            div_q  <= '0;
            sck_o  <= 1'b0;
            samp_q <= 1'b0;
        end else if (abort) begin
            active <= 1'b0;
            sck_o  <= 1'b0;
            div_q  <= '0;
        end else if (start) begin
            active <= 1'b1;
            sreg_q <= tx_byte;
            cnt_q  <= '0;
            div_q  <= '0;
            sck_o  <= 1'b0;
        end else if (active) begin
            if (is_master) begin
                div_q <= tick ? '0 : div_q + DIV_W'(1);
                if (tick) sck_o <= !sck_o;
            end
            if (sample_now) samp_q <= in_bit;
            if (shift_now) begin
                sreg_q <= {sreg_q[DATA_W-2:0], samp_q};
                cnt_q  <= cnt_q + CNT_W'(1);
                if (cnt_q == LAST_BIT) active <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/spi_stat_ctrl.sv
// Module: holding registers, status flags, role selection and mode-fault rules.
// Assumes: ss_q is synchronized; host strobes are single-cycle pulses.
module spi_stat_ctrl #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_en,
    input  logic              fault_det_en,
    input  logic              ss_q,
    input  logic              active,
    input  logic              done,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              wr_tx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_rx,
    input  logic              clr_fault,
    output logic              start,
    output logic              abort,
    output logic [DATA_W-1:0] tx_byte,
    output logic              tx_empty,
    output logic              rx_full,
    output logic [DATA_W-1:0] rx_data,
    output logic              mode_fault,
    output logic              is_master
);
    logic ss_prev_q;
    logic lock_q;
    logic master_hit;
    logic slave_drop;
    logic fault_set;

    // Purpose: apply the role-specific slave-select rules and choose start or abort.
    always_comb begin
        master_hit = is_master && fault_det_en && !ss_q;
        slave_drop = !is_master && active && ss_q;
        abort      = master_hit || slave_drop;
        fault_set  = master_hit || (slave_drop && fault_det_en);
        if (abort || active)  start = 1'b0;
        else if (is_master)   start = !tx_empty;
        else                  start = !ss_q && ss_prev_q;
    end

    // Purpose: keep the previous synchronized slave-select level.
    always_ff @(posedge clk) begin
        if (!rst_n) ss_prev_q <= 1'b1;
        else        ss_prev_q <= ss_q;
    end

    // Purpose: transmit holding register and its empty flag (a write beats a handoff).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_byte  <= '0;
            tx_empty <= 1'b1;
        end else if (wr_tx) begin
            tx_byte  <= wr_data;
            tx_empty <= 1'b0;
        end else if (start) begin
            tx_empty <= 1'b1;
        end
    end

    // Purpose: receive holding register and its full flag (completion beats a read).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
            rx_full <= 1'b0;
        end else if (done) begin
            rx_data <= rx_byte;
            rx_full <= 1'b1;
        end else if (rd_rx) begin
            rx_full <= 1'b0;
        end
    end

    // Purpose: sticky mode-fault flag, cleared by a write-one strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)          mode_fault <= 1'b0;
        else if (fault_set)  mode_fault <= 1'b1;
        else if (clr_fault)  mode_fault <= 1'b0;
    end

    // Purpose: role register with demotion lock after a master fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_master <= 1'b0;
            lock_q    <= 1'b0;
        end else if (master_hit) begin
            is_master <= 1'b0;
            lock_q    <= 1'b1;
        end else if (lock_q) begin
            if (!master_en) lock_q <= 1'b0;
        end else if (!active) begin
            is_master <= master_en;
        end
    end
endmodule

// File: rtl/spi_stat_irq.sv
// Module: per-source interrupt gating and merge.
// Assumes: flag and enable vectors share the same source order.
module spi_stat_irq #(
    parameter int N = 3
) (
    input  logic [N-1:0] flags,
    input  logic [N-1:0] enables,
    output logic         req
);
    logic [N-1:0] gated;
    for (genvar i = 0; i < N; i++) begin : g_src
        assign gated[i] = flags[i] & enables[i];
    end
    assign req = |gated;
endmodule

// File: rtl/spi_status_core.sv
// Module: top of the SPI status core; wires synchronizer, shifter, control and irq.
// Assumes: the slave SCK half period is at least three clk cycles.
module spi_status_core
    import spi_stat_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_en,
    input  logic              fault_det_en,
    input  logic              rx_ie,
    input  logic              tx_ie,
    input  logic              err_ie,
    input  logic              wr_tx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_rx,
    input  logic              clr_fault,
    output logic [DATA_W-1:0] rx_data,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              mode_fault,
    output logic              is_master,
    output logic              busy,
    output logic              irq,
    input  logic              ss_n_in,
    input  logic              sck_in,
    input  logic              mosi_in,
    input  logic              miso_in,
    output logic              sck_out,
    output logic              mosi_out,
    output logic              miso_out
);
    logic [SYNC_W-1:0] pins_raw;
    logic [SYNC_W-1:0] pins_q;
    logic              start;
    logic              abort;
    logic              done;
    logic [DATA_W-1:0] tx_byte;
    logic [DATA_W-1:0] rx_byte;
    logic              ser_out;
    logic [IRQ_SRCS-1:0] flag_vec;
    logic [IRQ_SRCS-1:0] en_vec;

    always_comb begin
        pins_raw           = '0;
        pins_raw[SS_BIT]   = ss_n_in;
        pins_raw[SCK_BIT]  = sck_in;
        pins_raw[MOSI_BIT] = mosi_in;
    end

    spi_stat_sync #(.W(SYNC_W), .RST_VAL(SYNC_IDLE)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_raw),
        .q     (pins_q)
    );

    spi_stat_shifter #(.DATA_W(DATA_W), .HALF_DIV(HALF_DIV)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_master (is_master),
        .start     (start),
        .abort     (abort),
        .tx_byte   (tx_byte),
        .sck_q     (pins_q[SCK_BIT]),
        .mosi_q    (pins_q[MOSI_BIT]),
        .miso_in   (miso_in),
        .active    (busy),
        .done      (done),
        .rx_byte   (rx_byte),
        .sck_o     (sck_out),
        .ser_out   (ser_out)
    );

    spi_stat_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .master_en    (master_en),
        .fault_det_en (fault_det_en),
        .ss_q         (pins_q[SS_BIT]),
        .active       (busy),
        .done         (done),
        .rx_byte      (rx_byte),
        .wr_tx        (wr_tx),
        .wr_data      (wr_data),
        .rd_rx        (rd_rx),
        .clr_fault    (clr_fault),
        .start        (start),
        .abort        (abort),
        .tx_byte      (tx_byte),
        .tx_empty     (tx_empty),
        .rx_full      (rx_full),
        .rx_data      (rx_data),
        .mode_fault   (mode_fault),
        .is_master    (is_master)
    );

    always_comb begin
        flag_vec          = '0;
        en_vec            = '0;
        flag_vec[SRC_RX]  = rx_full;
        flag_vec[SRC_TX]  = tx_empty;
        flag_vec[SRC_ERR] = mode_fault;
        en_vec[SRC_RX]    = rx_ie;
        en_vec[SRC_TX]    = tx_ie;
        en_vec[SRC_ERR]   = err_ie;
    end

    spi_stat_irq #(.N(IRQ_SRCS)) u_irq (
        .flags   (flag_vec),
        .enables (en_vec),
        .req     (irq)
    );

    assign mosi_out = is_master ? ser_out : 1'b0;
    assign miso_out = is_master ? 1'b0 : ser_out;
endmodule

// File: rtl/spi_status_checker.sv
// Module: port-level properties of spi_status_core, attached by bind.
// Assumes: synchronous active-low reset held from time zero.
module spi_status_checker (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic sck_out,
    input logic tx_empty,
    input logic rx_full,
    input logic mode_fault,
    input logic is_master,
    input logic irq,
    input logic wr_tx,
    input logic rd_rx,
    input logic clr_fault,
    input logic rx_ie,
    input logic tx_ie,
    input logic err_ie,
    input logic fault_det_en
);
    AST_SCK_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck_out); // R2
    AST_TXE_SET_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && !$past(wr_tx)) |-> tx_empty); // R3
    AST_READ_CLEARS_RXF: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rx && !busy) |=> !rx_full); // R4
    AST_IRQ_QUIET_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ie && !tx_ie && !err_ie) |-> !irq); // R5
    AST_FAULT_NEEDS_DET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_fault) |-> $past(fault_det_en)); // R7
    AST_MASTER_FAULT_DEMOTES: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mode_fault) && $past(is_master)) |-> (!is_master && !busy)); // R8
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr_fault) && !$past(fault_det_en)) |-> !mode_fault); // R9
endmodule

bind spi_status_core spi_status_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .sck_out      (sck_out),
    .tx_empty     (tx_empty),
    .rx_full      (rx_full),
    .mode_fault   (mode_fault),
    .is_master    (is_master),
    .irq          (irq),
    .wr_tx        (wr_tx),
    .rd_rx        (rd_rx),
    .clr_fault    (clr_fault),
    .rx_ie        (rx_ie),
    .tx_ie        (tx_ie),
    .err_ie       (err_ie),
    .fault_det_en (fault_det_en)
);

// File: tb/spi_status_core_tb_top.sv
// Bench: directed stimulus plus a behavioural per-cycle reference model.
module spi_status_core_tb_top;
    localparam int HALF = 2;
    localparam int XFER = 16 * HALF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master_en = 0, fault_det_en = 0, rx_ie = 0, tx_ie = 0, err_ie = 0;
    logic wr_tx = 0, rd_rx = 0, clr_fault = 0;
    logic [7:0] wr_data = '0;
    logic ss_n_in = 1, sck_in = 0, mosi_in = 0, miso_in = 0;
    logic [7:0] rx_data;
    logic tx_empty, rx_full, mode_fault, is_master, busy, irq;
    logic sck_out, mosi_out, miso_out;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    spi_status_core #(.DATA_W(8), .HALF_DIV(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .fault_det_en(fault_det_en),
        .rx_ie(rx_ie), .tx_ie(tx_ie), .err_ie(err_ie), .wr_tx(wr_tx), .wr_data(wr_data),
        .rd_rx(rd_rx), .clr_fault(clr_fault), .rx_data(rx_data), .tx_empty(tx_empty),
        .rx_full(rx_full), .mode_fault(mode_fault), .is_master(is_master), .busy(busy),
        .irq(irq), .ss_n_in(ss_n_in), .sck_in(sck_in), .mosi_in(mosi_in),
        .miso_in(miso_in), .sck_out(sck_out), .mosi_out(mosi_out), .miso_out(miso_out)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit ss_h[$];
    bit ck_h[$];
    bit di_h[$];
    bit rq[$];
    bit r_mst, r_lock, r_act, r_txe, r_rxf, r_flt;
    logic [7:0] r_txb, r_rxb, r_cur;
    int m_el, s_sh;
    bit t_ssq, t_ssp, t_kq, t_kp, t_dq, t_mf, t_sd, t_go, t_fin, t_a0, t_txe0;
    logic [7:0] t_rx;

    always @(posedge clk) begin
        if (!rst_n) begin
            ss_h = {1'b1, 1'b1, 1'b1};
            ck_h = {1'b0, 1'b0, 1'b0};
            di_h = {1'b0, 1'b0, 1'b0};
            rq.delete();
            r_mst = 0; r_lock = 0; r_act = 0; r_txe = 1; r_rxf = 0; r_flt = 0;
            r_txb = '0; r_rxb = '0; r_cur = '0; m_el = 0; s_sh = 0;
        end else begin
            t_ssq = ss_h[1]; t_ssp = ss_h[2];
            t_kq = ck_h[1]; t_kp = ck_h[2]; t_dq = di_h[1];
            t_a0 = r_act; t_txe0 = r_txe;
            t_mf = r_mst && fault_det_en && !t_ssq;
            t_sd = !r_mst && r_act && t_ssq;
            t_go = !(t_mf || t_sd) && !r_act && (r_mst ? !t_txe0 : (!t_ssq && t_ssp));
            t_fin = 0;
            if (t_mf || t_sd) r_act = 0;
            else if (t_go) begin
                r_act = 1; r_cur = r_txb; m_el = 0; s_sh = 0; rq.delete();
            end else if (r_act && r_mst) begin
                if (m_el % (2 * HALF) == HALF - 1) rq.push_back(miso_in);
                if (m_el == XFER - 1) begin t_fin = 1; r_act = 0; end
                m_el++;
            end else if (r_act) begin
                if (t_kq && !t_kp) rq.push_back(t_dq);
                else if (!t_kq && t_kp) begin
                    s_sh++;
                    if (s_sh == 8) begin t_fin = 1; r_act = 0; end
                end
            end
            if (t_fin) begin
                t_rx = '0;
                foreach (rq[i]) t_rx = {t_rx[6:0], rq[i]};
            end
            if (wr_tx) begin r_txe = 0; r_txb = wr_data; end
            else if (t_go) r_txe = 1;
            if (t_fin) begin r_rxf = 1; r_rxb = t_rx; end
            else if (rd_rx) r_rxf = 0;
            if (t_mf || (t_sd && fault_det_en)) r_flt = 1;
            else if (clr_fault) r_flt = 0;
            if (t_mf) begin r_mst = 0; r_lock = 1; end
            else if (r_lock) begin if (!master_en) r_lock = 0; end
            else if (!t_a0) r_mst = master_en;
            ss_h.push_front(ss_n_in); void'(ss_h.pop_back());
            ck_h.push_front(sck_in);  void'(ck_h.pop_back());
            di_h.push_front(mosi_in); void'(di_h.pop_back());
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3", "tx_empty", tx_empty, r_txe);
            chk("R4", "rx_full", rx_full, r_rxf);
            chk("R4", "rx_data", rx_data, r_rxb);
            chk("R7", "mode_fault", mode_fault, r_flt);
            chk("R10", "is_master", is_master, r_mst);
            chk("R2", "busy", busy, r_act);
            chk("R5", "irq", irq, (r_rxf && rx_ie) || (r_txe && tx_ie) || (r_flt && err_ie));
            chk("R2", "sck_out", sck_out, r_act && r_mst && ((m_el / HALF) % 2 == 1));
            if (r_act && r_mst)
                chk("R2", "mosi_out", mosi_out, r_cur[7 - m_el / (2 * HALF)]);
            if (r_act && !r_mst && s_sh < 8)
                chk("R6", "miso_out", miso_out, r_cur[7 - s_sh]);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_tx(input logic [7:0] b);
        wr_tx = 1; wr_data = b; tick(1); wr_tx = 0;
    endtask

    task automatic pulse_rd();
        rd_rx = 1; tick(1); rd_rx = 0;
    endtask

    task automatic pulse_clr();
        clr_fault = 1; tick(1); clr_fault = 0;
    endtask

    task automatic master_xfer(input logic [7:0] tx, input logic [7:0] pat,
                               output logic [7:0] seen);
        int idx = 0;
        int guard = 0;
        bit prev_sck = 0;
        seen = '0;
        miso_in = pat[7];
        put_tx(tx);
        do begin
            tick(1);
            if (prev_sck && !sck_out) begin
                idx++;
                if (idx < 8) miso_in = pat[7 - idx];
            end
            if (!prev_sck && sck_out) seen = {seen[6:0], mosi_out};
            prev_sck = sck_out;
            guard++;
        end while ((busy || guard < 3) && guard < 1000);
    endtask

    task automatic slave_xfer(input logic [7:0] din, input int nbits,
                              output logic [7:0] dout);
        dout = '0;
        ss_n_in = 0;
        tick(6);
        for (int i = 0; i < nbits; i++) begin
            mosi_in = din[7 - i];
            tick(3);
            dout = {dout[6:0], miso_out};
            sck_in = 1; tick(4);
            sck_in = 0; tick(4);
        end
        ss_n_in = 1;
        tick(5);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // ---------------- directed sequence ----------------
    initial begin
        logic [7:0] got;
        tick(3);
        rst_n = 1;
        // R1: reset state
        chk("R1", "tx_empty", tx_empty, 1);
        chk("R1", "rx_full", rx_full, 0);
        chk("R1", "mode_fault", mode_fault, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "is_master", is_master, 0);
        chk("R1", "irq", irq, 0);
        chk("R1", "sck_out", sck_out, 0);

        // R2/R4: master byte exchange
        fault_det_en = 1; master_en = 1; tick(3);
        chk("R10", "master role taken", is_master, 1);
        master_xfer(8'hA5, 8'h3C, got);
        chk("R2", "mosi byte on wire", got, 8'hA5);
        chk("R4", "received byte", rx_data, 8'h3C);
        chk("R4", "rx_full after byte", rx_full, 1);
        chk("R3", "tx_empty after handoff", tx_empty, 1);

        // R5: gating of each source
        rx_ie = 1; tick(1);
        chk("R5", "irq rx only", irq, 1);
        rx_ie = 0; tx_ie = 1; tick(1);
        chk("R5", "irq tx only", irq, 1);
        tx_ie = 0; tick(1);
        chk("R5", "irq none enabled", irq, 0);
        pulse_rd(); tick(1);
        chk("R4", "read clears rx_full", rx_full, 0);
        rx_ie = 1; tick(1);
        chk("R5", "irq rx enabled but empty", irq, 0);
        rx_ie = 0;

        // R3: write while shifting keeps the new byte pending, then auto-start
        miso_in = 1;
        put_tx(8'h81); tick(3);
        put_tx(8'h7E);
        chk("R3", "tx_empty after second write", tx_empty, 0);
        tick(3 * XFER);
        chk("R3", "tx_empty after both handoffs", tx_empty, 1);
        chk("R4", "all-ones byte", rx_data, 8'hFF);
        chk("R2", "idle after both", busy, 0);
        pulse_rd();

        // R8: detection off, low select ignored
        fault_det_en = 0; ss_n_in = 0; tick(8);
        chk("R8", "no fault with detection off", mode_fault, 0);
        chk("R8", "still master", is_master, 1);
        ss_n_in = 1; tick(4); fault_det_en = 1; tick(2);

        // R8/R11: master fault during a transfer
        put_tx(8'hF0); tick(5);
        chk("R2", "busy mid transfer", busy, 1);
        ss_n_in = 0;
        tick(1);
        chk("R11", "fault not yet after one edge", mode_fault, 0);
        tick(1);
        chk("R11", "fault not yet after two edges", mode_fault, 0);
        tick(1);
        chk("R11", "fault on third edge", mode_fault, 1);
        chk("R8", "transfer aborted", busy, 0);
        chk("R8", "demoted to slave", is_master, 0);
        chk("R8", "sck low after abort", sck_out, 0);
        chk("R5", "irq masked fault", irq, 0);
        err_ie = 1; tick(1);
        chk("R5", "irq fault enabled", irq, 1);
        err_ie = 0;
        ss_n_in = 1; tick(6);
        chk("R10", "locked in slave", is_master, 0);
        pulse_clr(); tick(1);
        chk("R9", "fault cleared", mode_fault, 0);
        master_en = 0; tick(3);
        chk("R10", "slave after release", is_master, 0);

        // R6: slave byte exchange
        put_tx(8'hC3);
        slave_xfer(8'h5A, 8, got);
        chk("R6", "miso byte on wire", got, 8'hC3);
        chk("R6", "slave received byte", rx_data, 8'h5A);
        chk("R6", "slave rx_full", rx_full, 1);
        chk("R3", "slave handoff sets tx_empty", tx_empty, 1);
        pulse_rd();

        // R7: select rises mid-byte with detection on
        put_tx(8'h11);
        slave_xfer(8'hFF, 4, got);
        chk("R7", "slave fault set", mode_fault, 1);
        chk("R7", "partial byte dropped", rx_full, 0);
        chk("R7", "slave idle after drop", busy, 0);
        pulse_clr(); tick(1);
        chk("R9", "fault cleared again", mode_fault, 0);

        // R7: same with detection off
        fault_det_en = 0;
        slave_xfer(8'hAA, 3, got);
        chk("R7", "no slave fault with detection off", mode_fault, 0);
        chk("R7", "no byte delivered", rx_full, 0);
        fault_det_en = 1;

        // R10: role returns to master once requested again
        master_en = 1; tick(3);
        chk("R10", "master again", is_master, 1);
        tick(4);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule